// File: doc/BRIEF.md
# Parallel Link Burst Source Framer

This block is the transmit-side sequencer of a 32-bit parallel point-to-point link. When told to start, it raises a request line and places a 32-bit routing word on the data lines. It then waits for the receiver to answer with a connect. After that it sends a programmed number of packets. It splits each packet into bursts of up to 256 words, and at most one of those bursts is short. Every burst needs one ready credit from the receiver. Credits may arrive early and are counted, and a burst starts only while the count is above zero.

Each word goes out with four byte-parity bits. One lateral check word follows each burst. Data come from a show-ahead word FIFO. If the FIFO runs dry, the block pauses inside the burst and keeps the burst line high. For link testing, the block can flip chosen parity bits on one word position in every burst. It can also flip chosen bits of every check word. The routing word, packet count, packet length and injection settings must be held stable while a connection is open.

Top module: `burst_src_framer`

## Requirements
- R1: While reset is high, and on the first cycle after it, request_o, packet_o, burst_o, dvalid_o, chk_o and fifo_rd_o are all 0.
- R2: A start_i pulse while idle raises request_o on the next cycle, with route_i on data_o and its byte parity on par_o. packet_o stays low until connect_i is seen high.
- R3: Every packet carries pkt_len_i data words, and a value of 0 counts as 1. With L = 256, the first burst has pkt_len_i mod L words when that is nonzero. Every other burst has L words.
- R4: Each ready_i cycle adds one credit, saturating at 2^CRED_W-1. Every burst takes one credit. burst_o rises only while the count is nonzero, so with no credit burst_o stays low.
- R5: Data words appear on data_o in FIFO order, each marked by dvalid_o, while burst_o and packet_o are high. An empty FIFO pauses the burst: dvalid_o goes low and burst_o stays high.
- R6: par_o[i] is odd parity over data_o[8i+7:8i] for every presented word, unless R8 applies.
- R7: In the cycle after a burst's last data word, chk_o is 1 and burst_o is 0. data_o then carries the bitwise XOR of all data words of that burst.
- R8: While inj_par_en_i is high, the word at 0-based position inj_word_i within each burst goes out with par_o equal to its odd parity XOR inj_par_mask_i.
- R9: While inj_chk_en_i is high, each check word is XORed with inj_chk_mask_i. Its par_o is the odd parity of the value actually sent.
- R10: After pkt_num_i packets (0 counts as 1), request_o falls. Between two packets of one connection, packet_o is low for exactly one cycle.
- R11: fifo_rd_o is high only in a cycle where a FIFO word is taken, and that word appears with dvalid_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a connection when idle |
| route_i | input | 32 | Routing word sent during the request phase |
| pkt_num_i | input | NPKT_W | Packets per connection |
| pkt_len_i | input | PLEN_W | Data words per packet |
| connect_i | input | 1 | Receiver accepts the connection |
| ready_i | input | 1 | One burst credit per high cycle |
| fifo_word_i | input | 32 | Head word of the show-ahead FIFO |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_rd_o | output | 1 | Pops the head word |
| inj_par_en_i | input | 1 | Enables parity corruption |
| inj_par_mask_i | input | 4 | Byte parity bits to flip |
| inj_word_i | input | log2(BURST_WORDS) | Word position in each burst to corrupt |
| inj_chk_en_i | input | 1 | Enables check word corruption |
| inj_chk_mask_i | input | 32 | Check word bits to flip |
| request_o | output | 1 | Connection request line |
| packet_o | output | 1 | Packet framing line |
| burst_o | output | 1 | Burst framing line |
| dvalid_o | output | 1 | data_o holds a burst data word |
| chk_o | output | 1 | data_o holds a burst check word |
| data_o | output | 32 | Link data lines |
| par_o | output | 4 | Byte parity lines |

## Verification
The assertions check the line hierarchy on every cycle: burst inside packet, packet inside request, data valid only inside a burst. They also check that a check word always directly follows a burst, that every burst start consumed a nonzero credit count, and that each FIFO pop becomes a valid word one cycle later. Only the bench scenarios can show the content: word order, burst length splitting for short, exact-multiple and one-over lengths, lateral XOR values, the effect of parity and check word injection at chosen positions, and the packet count before request drops.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_GAP,
        ST_WAIT,
        ST_BURST,
        ST_CHK,
        ST_END
    } lnk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LANES-1:0]  flip;
    } tx_sel_t;
endpackage

// File: rtl/lnk_credit_ctr.sv
module lnk_credit_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         grant,
    input  logic         take,
    output logic [W-1:0] count,
    output logic         avail
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({grant, take})
                2'b10:   if (count != TOP) count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign avail = (count != '0);
endmodule

// File: rtl/lnk_par_enc.sv
module lnk_par_enc #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] word,
    output logic [LANES-1:0]   par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = ~^word[8*g +: 8];
    end
endmodule

// File: rtl/lnk_burst_len.sv
module lnk_burst_len #(
    parameter int LOG = 8
) (
    input  logic [LOG-1:0] remain_low,
    output logic [LOG:0]   len
);
    localparam logic [LOG:0] FULL = {1'b1, {LOG{1'b0}}};

    assign len = (remain_low == '0) ? FULL : {1'b0, remain_low};
endmodule

// File: rtl/burst_src_framer.sv
module burst_src_framer
    import lnk_pkg::*;
#(
    parameter int BURST_WORDS = 256,
    parameter int PLEN_W      = 16,
    parameter int NPKT_W      = 8,
    parameter int CRED_W      = 4,
    localparam int LOG        = $clog2(BURST_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [31:0]       route_i,
    input  logic [NPKT_W-1:0] pkt_num_i,
    input  logic [PLEN_W-1:0] pkt_len_i,
    input  logic              connect_i,
    input  logic              ready_i,
    input  logic [31:0]       fifo_word_i,
    input  logic              fifo_empty_i,
    output logic              fifo_rd_o,
    input  logic              inj_par_en_i,
    input  logic [3:0]        inj_par_mask_i,
    input  logic [LOG-1:0]    inj_word_i,
    input  logic              inj_chk_en_i,
    input  logic [31:0]       inj_chk_mask_i,
    output logic              request_o,
    output logic              packet_o,
    output logic              burst_o,
    output logic              dvalid_o,
    output logic              chk_o,
    output logic [31:0]       data_o,
    output logic [3:0]        par_o
);
    localparam logic [PLEN_W-1:0] ONE_LEN = 1;
    localparam logic [NPKT_W-1:0] ONE_PKT = 1;

    lnk_state_e         st;
    logic [NPKT_W-1:0]  pkts_left;
    logic [PLEN_W-1:0]  words_left;
    logic [PLEN_W-1:0]  len_eff;
    logic [LOG:0]       cur_len;
    logic [LOG:0]       idx;
    logic [LOG:0]       next_len;
    logic [WORD_W-1:0]  lrc;
    logic [CRED_W-1:0]  cred_cnt;
    logic               cred_avail;
    logic               cred_take;
    logic               fifo_take;
    logic               last_word;
    tx_sel_t            tx;
    logic               tx_load;
    logic [LANES-1:0]   tx_par;

    assign len_eff   = (pkt_len_i == '0) ? ONE_LEN : pkt_len_i;
    assign fifo_take = (st == ST_BURST) && !fifo_empty_i;
    assign fifo_rd_o = fifo_take;
    assign cred_take = (st == ST_WAIT) && cred_avail;
    assign last_word = (idx == cur_len - 1'b1);

    lnk_credit_ctr #(.W(CRED_W)) u_cred (
        .clk   (clk),
        .rst   (rst),
        .grant (ready_i),
        .take  (cred_take),
        .count (cred_cnt),
        .avail (cred_avail)
    );

    lnk_burst_len #(.LOG(LOG)) u_blen (
        .remain_low (words_left[LOG-1:0]),
        .len        (next_len)
    );

    lnk_par_enc #(.LANES(LANES)) u_par (
        .word (tx.word),
        .par  (tx_par)
    );

    // word selection for the data lines
    always_comb begin
        tx      = '0;
        tx_load = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start_i) begin
                    tx.word = route_i;
                    tx_load = 1'b1;
                end
            end
            ST_BURST: begin
                if (fifo_take) begin
                    tx.word = fifo_word_i;
                    if (inj_par_en_i && (idx == {1'b0, inj_word_i}))
                        tx.flip = inj_par_mask_i;
                    tx_load = 1'b1;
                end
            end
            ST_CHK: begin
                tx.word = inj_chk_en_i ? (lrc ^ inj_chk_mask_i) : lrc;
                tx_load = 1'b1;
            end
            default: begin
                tx_load = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            request_o  <= 1'b0;
            packet_o   <= 1'b0;
            burst_o    <= 1'b0;
            dvalid_o   <= 1'b0;
            chk_o      <= 1'b0;
            data_o     <= '0;
            par_o      <= '0;
            pkts_left  <= '0;
            words_left <= '0;
            cur_len    <= '0;
            idx        <= '0;
            lrc        <= '0;
        end else begin
            dvalid_o <= 1'b0;
            chk_o    <= 1'b0;
            if (tx_load) begin
                data_o <= tx.word;
                par_o  <= tx_par ^ tx.flip;
            end
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        request_o <= 1'b1;
                        pkts_left <= pkt_num_i;
                        st        <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (connect_i) begin
                        packet_o   <= 1'b1;
                        words_left <= len_eff;
                        st         <= ST_WAIT;
                    end
                end
                ST_GAP: begin
                    packet_o   <= 1'b1;
                    words_left <= len_eff;
                    st         <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cred_avail) begin
                        burst_o <= 1'b1;
                        cur_len <= next_len;
                        idx     <= '0;
                        lrc     <= '0;
                        st      <= ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (fifo_take) begin
                        dvalid_o   <= 1'b1;
                        lrc        <= lrc ^ fifo_word_i;
                        idx        <= idx + 1'b1;
                        words_left <= words_left - 1'b1;
                        if (last_word) st <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    burst_o <= 1'b0;
                    chk_o   <= 1'b1;
                    st      <= (words_left == '0) ? ST_END : ST_WAIT;
                end
                ST_END: begin
                    packet_o <= 1'b0;
                    if (pkts_left <= ONE_PKT) begin
                        request_o <= 1'b0;
                        st        <= ST_IDLE;
                    end else begin
                        pkts_left <= pkts_left - 1'b1;
                        st        <= ST_GAP;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lnk_chk.sv
module lnk_chk #(
    parameter int CRED_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              request_o,
    input logic              packet_o,
    input logic              burst_o,
    input logic              dvalid_o,
    input logic              chk_o,
    input logic              fifo_rd_o,
    input logic [CRED_W-1:0] cred
);
    // R3
    pkt_in_req_chk: assert property (@(posedge clk) disable iff (rst)
        packet_o |-> request_o);

    // R5
    burst_in_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        burst_o |-> packet_o);

    // R5
    dvalid_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        dvalid_o |-> burst_o);

    // R7
    chk_after_burst_chk: assert property (@(posedge clk) disable iff (rst)
        chk_o |-> (!burst_o && packet_o && $past(burst_o)));

    // R4
    credit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_o) |-> ($past(cred) != '0));

    // R11
    rd_to_word_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |=> dvalid_o);

    // R10
    pkt_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(packet_o) && request_o) |=> (packet_o || !request_o));
endmodule

bind burst_src_framer lnk_chk #(.CRED_W(CRED_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .request_o (request_o),
    .packet_o  (packet_o),
    .burst_o   (burst_o),
    .dvalid_o  (dvalid_o),
    .chk_o     (chk_o),
    .fifo_rd_o (fifo_rd_o),
    .cred      (cred_cnt)
);

// File: tb/burst_src_framer_tb.sv
module burst_src_framer_tb;
    localparam int L = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] route_i = '0;
    logic [7:0]  pkt_num_i = '0;
    logic [15:0] pkt_len_i = '0;
    logic        connect_i = 1'b0;
    logic        ready_i = 1'b0;
    logic [31:0] fifo_word_i;
    logic        fifo_empty_i = 1'b0;
    logic        fifo_rd_o;
    logic        inj_par_en_i = 1'b0;
    logic [3:0]  inj_par_mask_i = '0;
    logic [7:0]  inj_word_i = '0;
    logic        inj_chk_en_i = 1'b0;
    logic [31:0] inj_chk_mask_i = '0;
    logic        request_o, packet_o, burst_o, dvalid_o, chk_o;
    logic [31:0] data_o;
    logic [3:0]  par_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    burst_src_framer u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .route_i(route_i),
        .pkt_num_i(pkt_num_i), .pkt_len_i(pkt_len_i), .connect_i(connect_i),
        .ready_i(ready_i), .fifo_word_i(fifo_word_i), .fifo_empty_i(fifo_empty_i),
        .fifo_rd_o(fifo_rd_o), .inj_par_en_i(inj_par_en_i),
        .inj_par_mask_i(inj_par_mask_i), .inj_word_i(inj_word_i),
        .inj_chk_en_i(inj_chk_en_i), .inj_chk_mask_i(inj_chk_mask_i),
        .request_o(request_o), .packet_o(packet_o), .burst_o(burst_o),
        .dvalid_o(dvalid_o), .chk_o(chk_o), .data_o(data_o), .par_o(par_o)
    );

    function automatic logic [31:0] gen(logic [31:0] n);
        return (n * 32'h9E3779B1) ^ {n[15:0], ~n[15:0]};
    endfunction

    function automatic logic [3:0] opar(logic [31:0] w);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) p[b] = ~^w[8*b +: 8];
        return p;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // FIFO model: an endless stream indexed by the pop count
    logic [31:0] rd_cnt;
    always @(posedge clk) begin
        if (rst) rd_cnt <= '0;
        else if (fifo_rd_o && !fifo_empty_i) rd_cnt <= rd_cnt + 1;
    end
    assign fifo_word_i = gen(rd_cnt);

    int empty_pct = 0;
    always @(negedge clk) fifo_empty_i <= (($urandom % 100) < empty_pct);

    // monitor and credit feeder
    bit          feed = 0;
    int          mcred = 0;
    bit          prev_req = 0, prev_pkt = 0, prev_burst = 0;
    int          rem = 0, bw = 0, blen = 0, npk = 0, exp_npk = 0;
    logic [31:0] exp_idx = 0;
    logic [31:0] lrc = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (request_o && !prev_req) begin
                check(data_o == route_i, "R2 route word", data_o, route_i);
                check(par_o == opar(route_i), "R2 route parity", {28'd0, par_o}, {28'd0, opar(route_i)});
                npk = 0;
            end
            if (packet_o && !prev_pkt) begin
                check(request_o == 1'b1, "R3 packet under request", {31'd0, request_o}, 32'd1);
                rem = (pkt_len_i == 0) ? 1 : int'(pkt_len_i);
                npk++;
                check(npk <= exp_npk, "R10 packet count", npk, exp_npk);
            end
            if (burst_o && !prev_burst) begin
                check(mcred > 0, "R4 credit before burst", mcred, 1);
                mcred--;
                blen = ((rem % L) == 0) ? L : (rem % L);
                bw = 0;
                lrc = '0;
            end
            if (dvalid_o) begin
                logic [3:0] fl;
                fl = (inj_par_en_i && bw == int'(inj_word_i)) ? inj_par_mask_i : 4'h0;
                check(burst_o && packet_o, "R5 word inside burst", {31'd0, burst_o}, 32'd1);
                check(data_o == gen(exp_idx), "R5 word order", data_o, gen(exp_idx));
                check(par_o == (opar(data_o) ^ fl), "R6/R8 word parity", {28'd0, par_o}, {28'd0, opar(data_o) ^ fl});
                lrc = lrc ^ data_o;
                bw++;
                exp_idx++;
                rem--;
            end
            if (chk_o) begin
                logic [31:0] ec;
                ec = inj_chk_en_i ? (lrc ^ inj_chk_mask_i) : lrc;
                check(bw == blen, "R3 burst length", bw, blen);
                check(!burst_o && packet_o, "R7 check word framing", {31'd0, burst_o}, 32'd0);
                check(data_o == ec, "R7/R9 check word", data_o, ec);
                check(par_o == opar(data_o), "R9 check word parity", {28'd0, par_o}, {28'd0, opar(data_o)});
            end
            if (!packet_o && prev_pkt)
                check(rem == 0, "R3 packet word total", rem, 0);
            if (!request_o && prev_req)
                check(npk == exp_npk, "R10 packets before drop", npk, exp_npk);
            ready_i <= 1'b0;
            if (feed && mcred < 2 && !ready_i) begin
                ready_i <= 1'b1;
                mcred++;
            end
            prev_req   = request_o;
            prev_pkt   = packet_o;
            prev_burst = burst_o;
        end
    end

    task automatic open_conn(int np, int pl, bit pe, logic [3:0] pm, logic [7:0] pw,
                             bit ce, logic [31:0] cm, logic [31:0] rt);
        @(negedge clk);
        pkt_num_i = np[7:0];
        pkt_len_i = pl[15:0];
        inj_par_en_i = pe;
        inj_par_mask_i = pm;
        inj_word_i = pw;
        inj_chk_en_i = ce;
        inj_chk_mask_i = cm;
        route_i = rt;
        exp_npk = (np == 0) ? 1 : np;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        // R2: request waits for connect
        check(request_o == 1'b1, "R2 request held", {31'd0, request_o}, 32'd1);
        check(packet_o == 1'b0, "R2 no packet before connect", {31'd0, packet_o}, 32'd0);
        connect_i = 1'b1;
    endtask

    task automatic wait_done();
        int n = 0;
        while (request_o && n < 40000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 40000) check(1'b0, "R10 request never dropped", n, 0);
        connect_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run(int np, int pl, bit pe, logic [3:0] pm, logic [7:0] pw,
                       bit ce, logic [31:0] cm, int pct);
        empty_pct = pct;
        open_conn(np, pl, pe, pm, pw, ce, cm, $urandom);
        wait_done();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1
        check({request_o, packet_o, burst_o, dvalid_o, chk_o, fifo_rd_o} == 6'd0,
              "R1 reset outputs", {26'd0, request_o, packet_o, burst_o, dvalid_o, chk_o, fifo_rd_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check({request_o, packet_o, burst_o, dvalid_o, chk_o} == 5'd0,
              "R1 idle after reset", {27'd0, request_o, packet_o, burst_o, dvalid_o, chk_o}, 32'd0);

        // R4: no credit, no burst
        open_conn(1, 4, 0, 4'h0, 8'd0, 0, 32'h0, 32'hA5C3_0F01);
        repeat (20) @(negedge clk);
        check(burst_o == 1'b0, "R4 burst withheld without credit", {31'd0, burst_o}, 32'd0);
        check(packet_o == 1'b1, "R3 packet open while waiting", {31'd0, packet_o}, 32'd1);
        feed = 1;
        wait_done();

        run(2, 259, 0, 4'h0, 8'd0, 0, 32'h0, 0);                  // R3 short then full
        run(3, 512, 1, 4'b0101, 8'd7, 1, 32'h8000_0001, 0);       // R8 R9 full bursts
        run(1, 256, 1, 4'b1000, 8'd255, 0, 32'h0, 0);             // R8 last position
        run(1, 257, 0, 4'h0, 8'd0, 1, 32'h0000_FF00, 30);         // R5 R11 stalls
        run(0, 0, 0, 4'h0, 8'd0, 0, 32'h0, 0);                    // R3 R10 zero as one
        run(1, 1, 1, 4'b1111, 8'd0, 1, 32'hFFFF_FFFF, 0);         // R8 R9 single word

        for (int i = 0; i < 6; i++) begin
            run(1 + int'($urandom % 3), 1 + int'($urandom % 700), 1'($urandom),
                4'($urandom), 8'($urandom), 1'($urandom), $urandom, int'($urandom % 40));
        end
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_up();
        end
    end
endmodule